// File: doc/BRIEF.md
# Half-Duplex Line Direction and Multidrop Address Filter

This block sits beside a UART's serial shifter and receive FIFO on a shared two-wire RS-485 bus. It drives the transceiver's driver-enable line by itself. The line asserts as soon as transmit data is waiting. It stays asserted while the shifter works. After the last stop bit has left, it stays asserted for a programmed number of bit times and then releases. Either of the two modem control outputs can carry this enable. The other output keeps following its software control bit.

On the receive side, the block filters 9-bit multidrop traffic. A character whose ninth bit is set is an address, and the block compares it with the station's own address. A matching address opens the receive gate and is itself written to the FIFO, so software can see which address selected the station. While the gate is open, data characters are written to the FIFO. A non-matching address closes the gate, and data characters are then dropped until a matching address arrives. With detection switched off, every character passes through.

Top module: `mdrop_link_ctrl`

## Requirements
- R1: With automatic direction off (auto_dir_en_i=0), rts_o equals manual_rts_i and dtr_o equals manual_dtr_i.
- R2: With automatic direction on, dir_sel_i=0 puts the direction on rts_o and dir_sel_i=1 puts it on dtr_o. The pin that is not selected follows its manual bit.
- R3: In automatic mode, the selected pin goes high in the same cycle that tx_empty_i goes low, before the shifter can start a frame.
- R4: Transmission ends when tx_empty_i=1 and tx_busy_i=0 are seen at a clock edge. With turn_dly_i=N>0, the selected pin stays high until the clock edge that samples the N-th bit_tick_i after that edge, and drops there. With N=0, it drops at the ending edge.
- R5: New transmit data during the turnaround hold keeps the pin high, and the delay count restarts from zero at the next end of transmission.
- R6: With addr_det_en_i=0, every received character is pushed with its low 8 bits, rx_gate_o=1, and addr_match_o stays 0.
- R7: With addr_det_en_i=1, a character with bit 8 set whose low 8 bits equal station_addr_i is pushed with its own value, pulses addr_match_o, and opens the gate (rx_gate_o=1).
- R8: With addr_det_en_i=1, a character with bit 8 clear is pushed only while the gate is open. A non-matching address (bit 8 set) is not pushed and closes the gate. The gate is closed after reset.
- R9: rx_push_o, rx_data_o and addr_match_o are registered. They are valid for one cycle, in the cycle after the edge that samples rx_valid_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| auto_dir_en_i | input | 1 | Hardware drives the direction pin |
| dir_sel_i | input | 1 | Direction pin select: 0 selects rts_o, 1 selects dtr_o |
| manual_rts_i | input | 1 | Software level for rts_o |
| manual_dtr_i | input | 1 | Software level for dtr_o |
| turn_dly_i | input | 8 | Turnaround delay in bit times |
| tx_empty_i | input | 1 | Transmit FIFO and shifter hold no data |
| tx_busy_i | input | 1 | Shifter is sending a frame |
| bit_tick_i | input | 1 | One-cycle pulse per bit time |
| addr_det_en_i | input | 1 | Enables multidrop address filtering |
| station_addr_i | input | 8 | Station address |
| rx_valid_i | input | 1 | Received character strobe |
| rx_char_i | input | 9 | Received character, bit 8 marks an address |
| rts_o | output | 1 | RTS pin level |
| dtr_o | output | 1 | DTR pin level |
| rx_gate_o | output | 1 | Receive gate currently open |
| rx_push_o | output | 1 | Write strobe to receive FIFO |
| rx_data_o | output | 8 | Byte written to receive FIFO |
| addr_match_o | output | 1 | Pulse on a matching address |

## Verification
The assertions check on every cycle the relations that hold at every edge. These are: the pin that is not selected follows its manual bit; the selected pin is high while data is pending; a push only follows a received strobe; a match pulse always comes with a push; and the pin releases during a nonzero hold only on a bit tick. The exact release edge after N ticks, the restart of the count on re-triggering, the FIFO byte values, and the gate closing on a foreign address can only be shown by the bench's directed scenarios.

// File: rtl/mdl_pkg.sv
package mdl_pkg;
  typedef enum logic [1:0] {
    DIR_IDLE = 2'd0,
    DIR_SEND = 2'd1,
    DIR_HOLD = 2'd2
  } dir_state_e;
endpackage

// File: rtl/mdl_dir_turn.sv
module mdl_dir_turn
  import mdl_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             auto_en_i,
  input  logic             tx_empty_i,
  input  logic             tx_busy_i,
  input  logic             bit_tick_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             dir_o
);
  dir_state_e       state_q, state_d;
  logic [DLY_W-1:0] cnt_q, cnt_d, cnt_inc;

  assign cnt_inc = cnt_q + 1'b1;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!auto_en_i) begin
      state_d = DIR_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        DIR_IDLE: if (!tx_empty_i) state_d = DIR_SEND;
        DIR_SEND: if (tx_empty_i && !tx_busy_i) begin
          cnt_d   = '0;
          state_d = (dly_i == '0) ? DIR_IDLE : DIR_HOLD;
        end
        DIR_HOLD: begin
          if (!tx_empty_i || tx_busy_i) begin
            state_d = DIR_SEND;
          end else if (bit_tick_i) begin
            if (cnt_inc == dly_i) state_d = DIR_IDLE;
            else                  cnt_d   = cnt_inc;
          end
        end
        default: state_d = DIR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= DIR_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // pending data raises the pin combinationally, ahead of any start bit
  assign dir_o = auto_en_i & (!tx_empty_i | (state_q != DIR_IDLE));
endmodule

// File: rtl/mdl_pin_mux.sv
module mdl_pin_mux #(
  parameter int N_PINS = 2
) (
  input  logic              auto_en_i,
  input  logic              sel_i,
  input  logic              dir_i,
  input  logic [N_PINS-1:0] manual_i,
  output logic [N_PINS-1:0] pin_o
);
  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    assign pin_o[i] = (auto_en_i && (sel_i == 1'(i))) ? dir_i : manual_i[i];
  end
endmodule

// File: rtl/mdl_addr_filter.sv
module mdl_addr_filter #(
  parameter int ADDR_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            det_en_i,
  input  logic [ADDR_W-1:0] station_i,
  input  logic            valid_i,
  input  logic [ADDR_W:0] char_i,
  output logic            gate_o,
  output logic            push_o,
  output logic [ADDR_W-1:0] data_o,
  output logic            match_o
);
  localparam int FLAG_BIT = ADDR_W;

  logic listen_q, is_addr, hit, push_d, listen_d;

  assign is_addr = char_i[FLAG_BIT];
  assign hit     = is_addr && (char_i[ADDR_W-1:0] == station_i);

  always_comb begin
    listen_d = listen_q;
    push_d   = 1'b0;
    if (valid_i) begin
      if (!det_en_i) begin
        push_d = 1'b1;
      end else if (is_addr) begin
        listen_d = hit;
        push_d   = hit;
      end else begin
        push_d = listen_q;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      listen_q <= 1'b0;
      push_o   <= 1'b0;
      match_o  <= 1'b0;
      data_o   <= '0;
    end else begin
      listen_q <= listen_d;
      push_o   <= push_d;
      match_o  <= valid_i && det_en_i && hit;
      if (push_d) data_o <= char_i[ADDR_W-1:0];
    end
  end

  assign gate_o = !det_en_i || listen_q;
endmodule

// File: rtl/mdrop_link_ctrl.sv
module mdrop_link_ctrl #(
  parameter int DLY_W  = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              auto_dir_en_i,
  input  logic              dir_sel_i,
  input  logic              manual_rts_i,
  input  logic              manual_dtr_i,
  input  logic [DLY_W-1:0]  turn_dly_i,
  input  logic              tx_empty_i,
  input  logic              tx_busy_i,
  input  logic              bit_tick_i,
  input  logic              addr_det_en_i,
  input  logic [ADDR_W-1:0] station_addr_i,
  input  logic              rx_valid_i,
  input  logic [ADDR_W:0]   rx_char_i,
  output logic              rts_o,
  output logic              dtr_o,
  output logic              rx_gate_o,
  output logic              rx_push_o,
  output logic [ADDR_W-1:0] rx_data_o,
  output logic              addr_match_o
);
  logic       dir;
  logic [1:0] pins;

  mdl_dir_turn #(.DLY_W(DLY_W)) u_dir (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .auto_en_i  (auto_dir_en_i),
    .tx_empty_i (tx_empty_i),
    .tx_busy_i  (tx_busy_i),
    .bit_tick_i (bit_tick_i),
    .dly_i      (turn_dly_i),
    .dir_o      (dir)
  );

  mdl_pin_mux #(.N_PINS(2)) u_mux (
    .auto_en_i (auto_dir_en_i),
    .sel_i     (dir_sel_i),
    .dir_i     (dir),
    .manual_i  ({manual_dtr_i, manual_rts_i}),
    .pin_o     (pins)
  );

  assign rts_o = pins[0];
  assign dtr_o = pins[1];

  mdl_addr_filter #(.ADDR_W(ADDR_W)) u_filt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .det_en_i  (addr_det_en_i),
    .station_i (station_addr_i),
    .valid_i   (rx_valid_i),
    .char_i    (rx_char_i),
    .gate_o    (rx_gate_o),
    .push_o    (rx_push_o),
    .data_o    (rx_data_o),
    .match_o   (addr_match_o)
  );
endmodule

// File: rtl/mdrop_link_ctrl_chk.sv
module mdrop_link_ctrl_chk #(
  parameter int DLY_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             auto_dir_en_i,
  input logic             dir_sel_i,
  input logic             manual_rts_i,
  input logic             manual_dtr_i,
  input logic [DLY_W-1:0] turn_dly_i,
  input logic             tx_empty_i,
  input logic             bit_tick_i,
  input logic             rx_valid_i,
  input logic             rts_o,
  input logic             dtr_o,
  input logic             rx_push_o,
  input logic             addr_match_o
);
  logic sel_pin;
  assign sel_pin = dir_sel_i ? dtr_o : rts_o;

  p_unsel_manual_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_dir_en_i |-> (dir_sel_i ? (rts_o == manual_rts_i) : (dtr_o == manual_dtr_i)));

  p_pending_drives_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_dir_en_i && !tx_empty_i) |-> sel_pin);

  p_release_on_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_dir_en_i && $past(auto_dir_en_i) && $stable(dir_sel_i) && $stable(turn_dly_i)
     && turn_dly_i != '0 && $past(sel_pin) && !sel_pin) |-> $past(bit_tick_i));

  p_push_after_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_o |-> $past(rx_valid_i));

  p_match_pushes_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_match_o |-> rx_push_o);
endmodule

bind mdrop_link_ctrl mdrop_link_ctrl_chk #(.DLY_W(DLY_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .auto_dir_en_i (auto_dir_en_i),
  .dir_sel_i     (dir_sel_i),
  .manual_rts_i  (manual_rts_i),
  .manual_dtr_i  (manual_dtr_i),
  .turn_dly_i    (turn_dly_i),
  .tx_empty_i    (tx_empty_i),
  .bit_tick_i    (bit_tick_i),
  .rx_valid_i    (rx_valid_i),
  .rts_o         (rts_o),
  .dtr_o         (dtr_o),
  .rx_push_o     (rx_push_o),
  .addr_match_o  (addr_match_o)
);

// File: tb/mdrop_link_ctrl_test.sv
module mdrop_link_ctrl_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       auto_dir_en_i = 1'b0, dir_sel_i = 1'b0;
  logic       manual_rts_i = 1'b0, manual_dtr_i = 1'b0;
  logic [7:0] turn_dly_i = '0;
  logic       tx_empty_i = 1'b1, tx_busy_i = 1'b0, bit_tick_i = 1'b0;
  logic       addr_det_en_i = 1'b0;
  logic [7:0] station_addr_i = 8'h5A;
  logic       rx_valid_i = 1'b0;
  logic [8:0] rx_char_i = '0;
  logic       rts_o, dtr_o, rx_gate_o, rx_push_o, addr_match_o;
  logic [7:0] rx_data_o;

  int checks = 0, errors = 0;

  always #10 clk_i = ~clk_i;

  mdrop_link_ctrl uut (.*);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic sel_pin();
    return dir_sel_i ? dtr_o : rts_o;
  endfunction

  task automatic tick();
    @(negedge clk_i) bit_tick_i = 1'b1;
    @(negedge clk_i) bit_tick_i = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    check("R1 reset rts", rts_o, 0);
    check("R6 reset gate", rx_gate_o, 1);
    check("R9 reset push", rx_push_o, 0);
    @(negedge clk_i) rst_ni = 1'b1;
  endtask

  task automatic t_manual();
    @(negedge clk_i) begin auto_dir_en_i = 0; manual_rts_i = 1; manual_dtr_i = 0; tx_empty_i = 0; end
    #1 check("R1 rts manual", rts_o, 1);
    check("R1 dtr manual", dtr_o, 0);
    @(negedge clk_i) begin manual_rts_i = 0; manual_dtr_i = 1; tx_empty_i = 1; end
    #1 check("R1 rts manual low", rts_o, 0);
    check("R1 dtr manual high", dtr_o, 1);
    manual_dtr_i = 0;
  endtask

  // one frame then N ticks of hold; checks pin after every tick
  task automatic t_frame(logic sel, int dly);
    @(negedge clk_i) begin auto_dir_en_i = 1; dir_sel_i = sel; turn_dly_i = 8'(dly); manual_rts_i = 1; manual_dtr_i = 1; end
    @(negedge clk_i) begin tx_empty_i = 0; tx_busy_i = 1; end
    #1 check("R3 pin on pending", sel_pin(), 1);
    check("R2 other pin manual", sel ? rts_o : dtr_o, 1);
    repeat (3) @(negedge clk_i);
    tx_empty_i = 1; tx_busy_i = 0;
    #1 check("R4 high before end edge", sel_pin(), 1);
    @(negedge clk_i);
    if (dly == 0) check("R4 zero delay release", sel_pin(), 0);
    for (int k = 1; k <= dly; k++) begin
      tick();
      check("R4 hold count", sel_pin(), (k < dly) ? 1 : 0);
    end
    manual_rts_i = 0; manual_dtr_i = 0;
  endtask

  task automatic t_retrigger();
    @(negedge clk_i) begin auto_dir_en_i = 1; dir_sel_i = 0; turn_dly_i = 8'd3; tx_empty_i = 0; tx_busy_i = 1; end
    @(negedge clk_i) begin tx_empty_i = 1; tx_busy_i = 0; end
    @(negedge clk_i);
    tick(); tick();
    check("R5 held before retrigger", rts_o, 1);
    @(negedge clk_i) begin tx_empty_i = 0; tx_busy_i = 1; end
    @(negedge clk_i) begin tx_empty_i = 1; tx_busy_i = 0; end
    @(negedge clk_i);
    tick(); tick();
    check("R5 count restarted", rts_o, 1);
    tick();
    check("R5 release after full delay", rts_o, 0);
  endtask

  task automatic send(string req, logic [8:0] c, logic exp_push, logic [7:0] exp_data,
                      logic exp_match, logic exp_gate);
    @(negedge clk_i) begin rx_valid_i = 1; rx_char_i = c; end
    @(negedge clk_i) rx_valid_i = 0;
    check({req, " push"}, rx_push_o, exp_push);
    if (exp_push) check({req, " data"}, rx_data_o, exp_data);
    check({req, " match"}, addr_match_o, exp_match);
    check({req, " gate"}, rx_gate_o, exp_gate);
    @(negedge clk_i);
    check({req, " push one cycle"}, rx_push_o, 0);
  endtask

  task automatic t_multidrop();
    addr_det_en_i = 1; station_addr_i = 8'h5A;
    #1 check("R8 gate closed after reset", rx_gate_o, 0);
    send("R8 data before address", 9'h011, 0, 8'h00, 0, 0);
    send("R7 matching address", 9'h15A, 1, 8'h5A, 1, 1);
    send("R8 data while open", 9'h0A5, 1, 8'hA5, 0, 1);
    send("R8 foreign address", 9'h133, 0, 8'h00, 0, 0);
    send("R8 data after foreign", 9'h022, 0, 8'h00, 0, 0);
    send("R7 reopen", 9'h15A, 1, 8'h5A, 1, 1);
  endtask

  task automatic t_passthru();
    @(negedge clk_i) addr_det_en_i = 0;
    send("R6 addr passes", 9'h1C3, 1, 8'hC3, 0, 1);
    send("R6 data passes", 9'h077, 1, 8'h77, 0, 1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_manual();
        t_frame(1'b0, 2);
        t_frame(1'b1, 4);
        t_frame(1'b0, 0);
        t_retrigger();
        t_multidrop();
        t_passthru();
      end
      begin
        repeat (100000) @(posedge clk_i);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule